// File: doc/BRIEF.md
# Crystal Reference and Timebase Divider

This block takes one clock derived from a crystal (11.16 MHz nominal) and divides it into three square waves. The first is a reference for a PLL phase comparator, at one of four rates picked by a 2-bit code. The second is a slow time-base tick. The third is a clock for an external controller. A one-cycle strobe marks each rising edge of the reference, so that the comparator can act on it without detecting edges itself.

All three outputs come from counter chains clocked by the single input clock. Each output is low for the first half of its period and high for the second half. When the divisor is odd, the high half is one cycle longer. A change of the reference code waits for the current reference period to finish, so no shortened pulse appears. A halt input stops only the reference chain. The time-base and the controller clock keep running during the halt, as they do in the standby mode of the tuner that uses this block.

The divisors for the nominal crystal are the parameter defaults:

| Output | Divisor | Rate at 11.16 MHz |
| --- | --- | --- |
| Reference, code 00 | 1240 | 9 kHz |
| Reference, code 01 | 1116 | 10 kHz |
| Reference, code 10 | 11160 | 1 kHz |
| Reference, code 11 | 2232 | 5 kHz |
| Time-base | 1,395,000 | 8 Hz |
| Controller clock | 186 | 60 kHz |

With another crystal between 8 and 12 MHz, the same divisors scale every rate in proportion to the crystal frequency.

Top module: `xtal_ref_timebase`

## Requirements
- R1: While rst_ni is low, ref_o, ref_stb_o, tb_o and ctl_clk_o are all 0, and they go to 0 as soon as rst_ni falls, without waiting for a clock edge.
- R2: The period of ref_o in clock cycles depends on ref_sel_i: code 00 gives DIV_SEL0 (1240), 01 gives DIV_SEL1 (1116), 10 gives DIV_SEL2 (11160) and 11 gives DIV_SEL3 (2232).
- R3: In each period of ref_o with divisor N, ref_o is low for floor(N/2) cycles and then high for the remaining cycles. After reset is released, the first rise of ref_o comes on the floor(N/2)-th clock edge.
- R4: A change of ref_sel_i has no effect on the period in progress. The new divisor applies from the next falling edge of ref_o.
- R5: ref_stb_o is high for exactly one cycle, namely the first cycle in which ref_o is high. It pulses once per reference period and never on two consecutive cycles.
- R6: ctl_clk_o has a period of CTL_DIV cycles (186), low for floor(CTL_DIV/2) cycles and high for the rest.
- R7: tb_o has a period of TB_DIV cycles (1,395,000), low for floor(TB_DIV/2) cycles and high for the rest.
- R8: While ref_halt_i is high, ref_o and ref_stb_o are held at 0 from the next clock edge, and tb_o and ctl_clk_o keep running unchanged. When ref_halt_i falls, a new reference period starts, using the code present at the first clock edge, and its first rise comes on the floor(N/2)-th edge.
- R9: For an odd divisor, the high phase of an output is one cycle longer than its low phase.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk_i | input | 1 | Crystal-derived system clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_sel_i | input | 2 | Reference rate code (00 = 9 kHz, 01 = 10 kHz, 10 = 1 kHz, 11 = 5 kHz at nominal crystal) |
| ref_halt_i | input | 1 | Stops the reference chain only; tb_o and ctl_clk_o keep running |
| ref_o | output | 1 | Phase-comparison reference square wave |
| ref_stb_o | output | 1 | One-cycle pulse in the first high cycle of ref_o |
| tb_o | output | 1 | Time-base square wave |
| ctl_clk_o | output | 1 | Controller clock square wave |

## Verification
The hardest case to reach from the ports is a code change that lands in the middle of a reference period. The bench waits until it sees the first high cycle of ref_o, changes the code in that same cycle, and checks two things. The high phase still in progress must keep the old length, and the next full period must have the new length.

A second hard case is resuming after a halt. The code is changed while the reference is halted, and the bench then counts the edges up to the first rise after the halt is released.

To bring the time-base and controller periods within reach of a short run, the bench uses small divisors, some of them odd.

// File: rtl/xtal_div_pkg.sv
package xtal_div_pkg;

  typedef enum logic [1:0] {
    SEL_9K  = 2'b00,
    SEL_10K = 2'b01,
    SEL_1K  = 2'b10,
    SEL_5K  = 2'b11
  } ref_sel_e;

  function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                       input int unsigned c, input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

  function automatic int unsigned cnt_bits(input int unsigned n);
    return (n > 2) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/sq_fixed_div.sv
module sq_fixed_div #(
  parameter int unsigned DIV = 186
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic sq_o
);
  localparam int unsigned CW = xtal_div_pkg::cnt_bits(DIV);
  localparam int unsigned LO = DIV / 2;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          sq_q;

  always_comb cnt_d = (cnt_q == CW'(DIV - 1)) ? '0 : cnt_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sq_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      sq_q  <= (cnt_d >= CW'(LO));
    end
  end

  assign sq_o = sq_q;

  assert_fall_at_wrap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CW'(DIV - 1)) |=> !sq_q);

  assert_rise_at_half_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sq_q) |-> (cnt_q == CW'(LO)));

endmodule

// File: rtl/ref_sel_decode.sv
module ref_sel_decode
  import xtal_div_pkg::*;
#(
  parameter int unsigned W        = 14,
  parameter int unsigned DIV_SEL0 = 1240,
  parameter int unsigned DIV_SEL1 = 1116,
  parameter int unsigned DIV_SEL2 = 11160,
  parameter int unsigned DIV_SEL3 = 2232
) (
  input  ref_sel_e       sel_i,
  output logic [W-1:0]   div_o
);
  always_comb begin
    unique case (sel_i)
      SEL_9K:  div_o = W'(DIV_SEL0);
      SEL_10K: div_o = W'(DIV_SEL1);
      SEL_1K:  div_o = W'(DIV_SEL2);
      default: div_o = W'(DIV_SEL3);
    endcase
  end
endmodule

// File: rtl/ref_sq_div.sv
module ref_sq_div #(
  parameter int unsigned W = 14
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         halt_i,
  input  logic [W-1:0] div_i,
  output logic         sq_o,
  output logic         stb_o
);
  logic [W-1:0] cnt_q, cnt_d, div_q, div_d, eff_div, lo_d;
  logic         armed_q, term, sq_q, stb_q;

  // divisor is sampled at period start only; unarmed means a period is just starting
  always_comb begin
    eff_div = armed_q ? div_q : div_i;
    term    = (cnt_q == eff_div - 1'b1);
    div_d   = (!armed_q || term) ? div_i : div_q;
    cnt_d   = term ? '0 : cnt_q + 1'b1;
    lo_d    = div_d >> 1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      div_q   <= '0;
      armed_q <= 1'b0;
      sq_q    <= 1'b0;
      stb_q   <= 1'b0;
    end else if (halt_i) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
      sq_q    <= 1'b0;
      stb_q   <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      div_q   <= div_d;
      armed_q <= 1'b1;
      sq_q    <= (cnt_d >= lo_d);
      stb_q   <= (cnt_d == lo_d);
    end
  end

  assign sq_o  = sq_q;
  assign stb_o = stb_q;

  assert_stb_only_on_rise_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_q |-> $rose(sq_q));

  assert_rise_has_stb_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sq_q) |-> stb_q);

  assert_halt_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_i |=> (!sq_q && !stb_q));

  assert_div_switch_at_wrap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && $past(armed_q) && (div_q != $past(div_q))) |-> (cnt_q == '0));

  assert_fall_at_wrap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(sq_q) && !$past(halt_i)) |-> (cnt_q == '0));

endmodule

// File: rtl/xtal_ref_timebase.sv
module xtal_ref_timebase
  import xtal_div_pkg::*;
#(
  parameter int unsigned DIV_SEL0 = 1240,
  parameter int unsigned DIV_SEL1 = 1116,
  parameter int unsigned DIV_SEL2 = 11160,
  parameter int unsigned DIV_SEL3 = 2232,
  parameter int unsigned TB_DIV   = 1395000,
  parameter int unsigned CTL_DIV  = 186
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] ref_sel_i,
  input  logic       ref_halt_i,
  output logic       ref_o,
  output logic       ref_stb_o,
  output logic       tb_o,
  output logic       ctl_clk_o
);
  localparam int unsigned REF_MAX = max4(DIV_SEL0, DIV_SEL1, DIV_SEL2, DIV_SEL3);
  localparam int unsigned REF_W   = $clog2(REF_MAX + 1);

  logic [REF_W-1:0] ref_div;

  ref_sel_decode #(
    .W(REF_W), .DIV_SEL0(DIV_SEL0), .DIV_SEL1(DIV_SEL1),
    .DIV_SEL2(DIV_SEL2), .DIV_SEL3(DIV_SEL3)
  ) u_dec (
    .sel_i (ref_sel_e'(ref_sel_i)),
    .div_o (ref_div)
  );

  ref_sq_div #(.W(REF_W)) u_ref (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .halt_i (ref_halt_i),
    .div_i  (ref_div),
    .sq_o   (ref_o),
    .stb_o  (ref_stb_o)
  );

  sq_fixed_div #(.DIV(TB_DIV)) u_tb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sq_o   (tb_o)
  );

  sq_fixed_div #(.DIV(CTL_DIV)) u_ctl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sq_o   (ctl_clk_o)
  );

  assert_reset_low_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (!ref_o && !ref_stb_o && !tb_o && !ctl_clk_o));

endmodule

// File: tb/sim_xtal_ref_timebase.sv
module sim_xtal_ref_timebase;
  logic clk = 1'b0;
  logic rst_ni, halt;
  logic [1:0] sel;
  logic ref_o, ref_stb_o, tb_o, ctl_clk_o;
  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  xtal_ref_timebase #(
    .DIV_SEL0(12), .DIV_SEL1(11), .DIV_SEL2(20), .DIV_SEL3(8),
    .TB_DIV(50), .CTL_DIV(7)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .ref_sel_i(sel), .ref_halt_i(halt),
    .ref_o(ref_o), .ref_stb_o(ref_stb_o), .tb_o(tb_o), .ctl_clk_o(ctl_clk_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic sig(input int w);
    case (w)
      0: return ref_o;
      1: return ref_stb_o;
      2: return tb_o;
      default: return ctl_clk_o;
    endcase
  endfunction

  task automatic sync_fall(input int w);
    while (sig(w) == 1'b0) @(negedge clk);
    while (sig(w) == 1'b1) @(negedge clk);
  endtask

  task automatic meas(input int w, output int lo, output int hi);
    sync_fall(w);
    lo = 0; hi = 0;
    while (sig(w) == 1'b0) begin lo++; @(negedge clk); end
    while (sig(w) == 1'b1) begin hi++; @(negedge clk); end
  endtask

  task automatic t_reset_start;
    int k;
    rst_ni = 1'b0; sel = 2'b00; halt = 1'b0;
    repeat (3) @(negedge clk);
    chk({ref_o, ref_stb_o, tb_o, ctl_clk_o} == 4'b0, "R1 outputs in reset",
        {ref_o, ref_stb_o, tb_o, ctl_clk_o}, 0);
    rst_ni = 1'b1;
    k = 0;
    do begin @(negedge clk); k++; end while (!ref_o && k < 100);
    chk(k == 6, "R3 first rise edge", k, 6);
    chk(ref_stb_o == 1'b1, "R5 strobe with rise", ref_stb_o, 1);
    @(negedge clk);
    chk(ref_stb_o == 1'b0, "R5 strobe one cycle", ref_stb_o, 0);
  endtask

  task automatic t_select(input logic [1:0] code, input int elo, input int ehi);
    int lo, hi;
    sel = code;
    meas(0, lo, hi);
    chk(lo == elo, $sformatf("R2 sel %b low", code), lo, elo);
    chk(hi == ehi, $sformatf("R2 R9 sel %b high", code), hi, ehi);
  endtask

  task automatic t_mid_change;
    int lo, hi;
    sel = 2'b00;
    meas(0, lo, hi);
    while (ref_o == 1'b1) @(negedge clk);
    while (ref_o == 1'b0) @(negedge clk);
    sel = 2'b10;
    hi = 0;
    while (ref_o == 1'b1) begin hi++; @(negedge clk); end
    chk(hi == 6, "R4 old high phase kept", hi, 6);
    lo = 0;
    while (ref_o == 1'b0) begin lo++; @(negedge clk); end
    hi = 0;
    while (ref_o == 1'b1) begin hi++; @(negedge clk); end
    chk(lo == 10 && hi == 10, "R4 new period 10/10", lo * 100 + hi, 1010);
  endtask

  task automatic t_strobe;
    int stbs = 0, rises = 0, dbl = 0;
    logic prev_r, prev_s;
    sel = 2'b11;
    prev_r = ref_o; prev_s = ref_stb_o;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (ref_stb_o) stbs++;
      if (ref_o && !prev_r) rises++;
      if (ref_stb_o && prev_s) dbl++;
      prev_r = ref_o; prev_s = ref_stb_o;
    end
    chk(stbs == rises && rises > 0, "R5 strobe per rise", stbs, rises);
    chk(dbl == 0, "R5 no back-to-back strobe", dbl, 0);
  endtask

  task automatic t_fixed;
    int lo, hi;
    meas(3, lo, hi);
    chk(lo == 3, "R6 ctl low", lo, 3);
    chk(hi == 4, "R6 R9 ctl high", hi, 4);
    meas(2, lo, hi);
    chk(lo == 25 && hi == 25, "R7 tb halves", lo * 100 + hi, 2525);
  endtask

  task automatic t_halt;
    int bad = 0, crises = 0, k;
    logic pc;
    @(negedge clk);
    halt = 1'b1;
    @(negedge clk);
    pc = ctl_clk_o;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (ref_o || ref_stb_o) bad++;
      if (ctl_clk_o && !pc) crises++;
      pc = ctl_clk_o;
    end
    chk(bad == 0, "R8 reference quiet in halt", bad, 0);
    chk(crises >= 5, "R8 ctl runs in halt", crises, 5);
    sel = 2'b01;
    halt = 1'b0;
    k = 0;
    do begin @(negedge clk); k++; end while (!ref_o && k < 100);
    chk(k == 5, "R8 first rise after halt", k, 5);
  endtask

  task automatic t_reset_mid;
    rst_ni = 1'b0;
    #1;
    chk({ref_o, ref_stb_o, tb_o, ctl_clk_o} == 4'b0, "R1 async clear",
        {ref_o, ref_stb_o, tb_o, ctl_clk_o}, 0);
    repeat (2) @(negedge clk);
    chk({ref_o, ref_stb_o, tb_o, ctl_clk_o} == 4'b0, "R1 held in reset",
        {ref_o, ref_stb_o, tb_o, ctl_clk_o}, 0);
  endtask

  initial begin
    t_reset_start();
    t_select(2'b00, 6, 6);
    t_select(2'b01, 5, 6);
    t_select(2'b10, 10, 10);
    t_select(2'b11, 4, 4);
    t_mid_change();
    t_strobe();
    t_fixed();
    t_halt();
    t_reset_mid();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule